// File: doc/BRIEF.md
# Power-On Reset and Output-Enable Sequencer

This block decides when the rest of the chip is held in reset and which output pads may drive. There are three reset causes. The first is a line-locked clock that has stopped. The second is an undervoltage flag raised by the analog supply monitors. The third is the chip-enable pin held low. While any cause is present, the internal reset is active and every pad enable is off, so all outputs float.

Once every cause has cleared and stayed clear, the internal reset is released. The two clock-output pads and the serial-data pad are then re-enabled without further action. The remaining outputs stay off until the register interface writes their enable bits. An external reset indicator stays low for a fixed tail of monitored-clock edges after the release, so that neighbouring devices can use it as their own reset. A new cause during that tail starts the whole sequence again.

All logic runs on a free-running reference clock. The monitored clock is treated as a sampled data input.

Top module: `rst_sequencer`

## Requirements
- R1: If the synchronized monitored clock shows no rising edge for MISS_LIMIT (64) consecutive reference cycles, this counts as a reset cause until the next rising edge.
- R2: A high level on `underVolt` is a reset cause. A single-cycle pulse is enough to enter reset.
- R3: A low level on `chipEnable` is a reset cause.
- R4: `chipEnable`, `underVolt` and the monitored clock each pass through a two-flop synchronizer. The internal reset (`intRstN` low) releases only after STABLE_CYC (16) consecutive cycles with no cause.
- R5: While `intRstN` is low, `clkOutEn`, `sdaOutEn` and `progOutEn` are all zero.
- R6: After release, `resIndN` stays low until TAIL_EDGES (128) rising edges of the monitored clock have been seen, and then goes high. `resIndN` is never high while `intRstN` is low.
- R7: From the cycle `intRstN` rises, `clkOutEn` is 2'b11 and `sdaOutEn` is 1, with no register write needed.
- R8: `progOutEn` changes only through `regWr`. A write loads `regWrData` in the following cycle. Writes made while in reset are ignored, and bit i of the data enables output i.
- R9: A cause during the indicator tail, or after it, returns the block to reset and clears all programmed enables. They stay cleared after the next release.
- R10: While `rstN` is low, the block is in reset: `intRstN`, `resIndN` and every enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| lineClk | input | 1 | Monitored line-locked clock, sampled as data |
| chipEnable | input | 1 | Chip-enable pin, low forces reset |
| underVolt | input | 1 | Supply-below-threshold flag from the analog monitors |
| regWr | input | 1 | Write strobe for the programmable enables |
| regWrData | input | NUM_PROG | Programmable enable bits to load |
| intRstN | output | 1 | Internal reset, active low |
| resIndN | output | 1 | External reset indicator, active low |
| clkOutEn | output | 2 | Drive enables for the two clock-output pads |
| sdaOutEn | output | 1 | Drive enable for the serial-data pad |
| progOutEn | output | NUM_PROG | Drive enables for the programmable outputs |

## Verification
A change on `chipEnable` or `underVolt` that is sampled at one clock edge reaches the state register two edges later. So `intRstN` falls three edges after the input is sampled. A write on `regWr` shows up on `progOutEn` one edge later. The indicator rises in the cycle after the 128th synchronized monitored-clock edge, and each such edge itself trails the pin by three reference edges. The bench's behavioural model advances on every rising edge with these latencies. Stimulus changes just after the falling edge, and the outputs are compared with the model at each falling edge, so every comparison lands in a settled cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    SEQ_RESET = 2'd0,
    SEQ_TAIL  = 2'd1,
    SEQ_RUN   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tailClr;
    logic tailInc;
    logic progClr;
    logic progLoad;
  } seqStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic cause;
    logic stableDone;
    logic tailDone;
  } seqStatus_t;
endpackage

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int MISS_LIMIT  = 64,
  parameter int STABLE_CYC  = 16,
  parameter int TAIL_EDGES  = 128,
  parameter int NUM_PROG    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                lineClk,
  input  logic                chipEnable,
  input  logic                underVolt,
  input  logic                regWr,
  input  logic [NUM_PROG-1:0] regWrData,
  input  seqStrobe_t          strobe,
  output seqStatus_t          status,
  output logic [NUM_PROG-1:0] progBits
);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam int TW = $clog2(TAIL_EDGES + 1);
  localparam logic [MW-1:0] MISS_MAX  = MW'(MISS_LIMIT);
  localparam logic [SW-1:0] STAB_MAX  = SW'(STABLE_CYC);
  localparam logic [TW-1:0] TAIL_LAST = TW'(TAIL_EDGES - 1);

  logic [SYNC_STAGES-1:0] ceSync, uvSync;
  logic [SYNC_STAGES:0]   lineSync;   // one extra stage for edge detect
  logic [MW-1:0] missCnt;
  logic [SW-1:0] stableCnt;
  logic [TW-1:0] tailCnt;
  logic lineEdge, clkMissing, causeNow;

  // synchronizer chains
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      ceSync   <= '0;
      uvSync   <= '0;
      lineSync <= '0;
    end else begin
      ceSync   <= {ceSync[SYNC_STAGES-2:0], chipEnable};
      uvSync   <= {uvSync[SYNC_STAGES-2:0], underVolt};
      lineSync <= {lineSync[SYNC_STAGES-1:0], lineClk};
    end
  end

  assign lineEdge   = lineSync[SYNC_STAGES-1] & ~lineSync[SYNC_STAGES];
  assign clkMissing = (missCnt == MISS_MAX);
  assign causeNow   = ~ceSync[SYNC_STAGES-1] | uvSync[SYNC_STAGES-1] | clkMissing;

  // missing-clock watchdog and cause-free stability counter
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      missCnt   <= '0;
      stableCnt <= '0;
    end else begin
      if (lineEdge)               missCnt <= '0;
      else if (!clkMissing)       missCnt <= missCnt + 1'b1;
      if (causeNow)               stableCnt <= '0;
      else if (stableCnt != STAB_MAX) stableCnt <= stableCnt + 1'b1;
    end
  end

  // indicator tail edge counter
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                          tailCnt <= '0;
    else if (strobe.tailClr)            tailCnt <= '0;
    else if (strobe.tailInc && lineEdge) tailCnt <= tailCnt + 1'b1;
  end

  // programmed output enables
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                           progBits <= '0;
    else if (strobe.progClr)             progBits <= '0;
    else if (strobe.progLoad && regWr)   progBits <= regWrData;
  end

  assign status.cause      = causeNow;
  assign status.stableDone = (stableCnt == STAB_MAX);
  assign status.tailDone   = strobe.tailInc && lineEdge && (tailCnt == TAIL_LAST);
endmodule

// File: rtl/rsq_control.sv
module rsq_control
  import rsq_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output seqState_t  state
);
  seqState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      SEQ_RESET: if (status.stableDone && !status.cause) nextState = SEQ_TAIL;
      SEQ_TAIL: begin
        if (status.cause)         nextState = SEQ_RESET;
        else if (status.tailDone) nextState = SEQ_RUN;
      end
      SEQ_RUN:  if (status.cause) nextState = SEQ_RESET;
      default:  nextState = SEQ_RESET;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) state <= SEQ_RESET;
    else       state <= nextState;
  end

  always_comb begin
    strobe.tailClr  = (state == SEQ_RESET);
    strobe.tailInc  = (state == SEQ_TAIL);
    strobe.progClr  = (state == SEQ_RESET) || status.cause;
    strobe.progLoad = (state != SEQ_RESET);
  end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rsq_pkg::*;
#(
  parameter int MISS_LIMIT = 64,
  parameter int STABLE_CYC = 16,
  parameter int TAIL_EDGES = 128,
  parameter int NUM_PROG   = 6
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                lineClk,
  input  logic                chipEnable,
  input  logic                underVolt,
  input  logic                regWr,
  input  logic [NUM_PROG-1:0] regWrData,
  output logic                intRstN,
  output logic                resIndN,
  output logic [1:0]          clkOutEn,
  output logic                sdaOutEn,
  output logic [NUM_PROG-1:0] progOutEn
);
  seqStrobe_t strobe;
  seqStatus_t status;
  seqState_t  state;
  logic [NUM_PROG-1:0] progBits;

  rsq_datapath #(
    .MISS_LIMIT (MISS_LIMIT),
    .STABLE_CYC (STABLE_CYC),
    .TAIL_EDGES (TAIL_EDGES),
    .NUM_PROG   (NUM_PROG),
    .SYNC_STAGES(2)
  ) u_dp (
    .refClk    (refClk),
    .rstN      (rstN),
    .lineClk   (lineClk),
    .chipEnable(chipEnable),
    .underVolt (underVolt),
    .regWr     (regWr),
    .regWrData (regWrData),
    .strobe    (strobe),
    .status    (status),
    .progBits  (progBits)
  );

  rsq_control u_ctl (
    .refClk(refClk),
    .rstN  (rstN),
    .status(status),
    .strobe(strobe),
    .state (state)
  );

  assign intRstN   = (state != SEQ_RESET);
  assign resIndN   = (state == SEQ_RUN);
  assign clkOutEn  = {2{intRstN}};
  assign sdaOutEn  = intRstN;
  assign progOutEn = progBits;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int NUM_PROG = 6
) (
  input logic                refClk,
  input logic                rstN,
  input logic                chipEnable,
  input logic                underVolt,
  input logic                intRstN,
  input logic                resIndN,
  input logic [1:0]          clkOutEn,
  input logic                sdaOutEn,
  input logic [NUM_PROG-1:0] progOutEn
);
  AST_RESET_PADS_OFF: assert property (@(posedge refClk) disable iff (!rstN)
    !intRstN |-> (clkOutEn == 2'b00 && !sdaOutEn && progOutEn == '0)); // R5
  AST_IND_BEHIND_INT: assert property (@(posedge refClk) disable iff (!rstN)
    !intRstN |-> !resIndN); // R6
  AST_AUTO_PADS_ON: assert property (@(posedge refClk) disable iff (!rstN)
    intRstN |-> (clkOutEn == 2'b11 && sdaOutEn)); // R7
  AST_UV_ENTERS_RESET: assert property (@(posedge refClk) disable iff (!rstN)
    $past(underVolt, 3) |-> !intRstN); // R2
  AST_CE_ENTERS_RESET: assert property (@(posedge refClk) disable iff (!rstN)
    !$past(chipEnable, 3) |-> !intRstN); // R3
  AST_PROG_CLEAR_AT_RELEASE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(intRstN) |-> progOutEn == '0); // R9
endmodule

bind rst_sequencer rst_sequencer_chk #(.NUM_PROG(NUM_PROG)) u_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .chipEnable(chipEnable),
  .underVolt (underVolt),
  .intRstN   (intRstN),
  .resIndN   (resIndN),
  .clkOutEn  (clkOutEn),
  .sdaOutEn  (sdaOutEn),
  .progOutEn (progOutEn)
);

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/1ps
module rst_sequencer_tb;
  localparam int NP = 6;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic lineClk = 1'b0;
  logic chipEnable = 1'b1;
  logic underVolt = 1'b0;
  logic regWr = 1'b0;
  logic [NP-1:0] regWrData = '0;
  logic intRstN, resIndN, sdaOutEn;
  logic [1:0] clkOutEn;
  logic [NP-1:0] progOutEn;

  int compared = 0;
  int mismatched = 0;
  bit lineRun = 1'b1;
  int lineDiv = 0;
  string curReq = "R10";

  always #5 refClk = ~refClk;

  rst_sequencer u_dut (
    .refClk(refClk), .rstN(rstN), .lineClk(lineClk),
    .chipEnable(chipEnable), .underVolt(underVolt),
    .regWr(regWr), .regWrData(regWrData),
    .intRstN(intRstN), .resIndN(resIndN), .clkOutEn(clkOutEn),
    .sdaOutEn(sdaOutEn), .progOutEn(progOutEn)
  );

  // monitored clock: rising edge every 4 reference cycles when running
  always @(negedge refClk) begin
    if (lineRun) begin
      lineDiv = lineDiv + 1;
      if (lineDiv == 2) begin
        lineDiv = 0;
        lineClk <= ~lineClk;
      end
    end
  end

  // behavioural reference model: 0 = held, 1 = indicator tail, 2 = running
  int mPhase = 0, mTail = 0, mQuiet = 0, mSilent = 0;
  int pinHist[$] = '{0, 0, 0};   // monitored clock samples, newest first
  int ceHist[$]  = '{0, 0};
  int uvHist[$]  = '{0, 0};
  int mProg = 0;

  always @(posedge refClk) begin
    if (!rstN) begin
      mPhase = 0; mTail = 0; mQuiet = 0; mSilent = 0; mProg = 0;
      pinHist = '{0, 0, 0}; ceHist = '{0, 0}; uvHist = '{0, 0};
    end else begin
      bit rising, anyCause;
      int nPhase, nTail;
      rising   = (pinHist[1] == 1) && (pinHist[2] == 0);
      anyCause = (ceHist[1] == 0) || (uvHist[1] == 1) || (mSilent >= 64);
      nPhase = mPhase; nTail = mTail;
      if (mPhase == 0) begin
        nTail = 0;
        if (mQuiet >= 16 && !anyCause) nPhase = 1;
      end else if (anyCause) begin
        nPhase = 0;
      end else if (mPhase == 1 && rising) begin
        if (mTail + 1 == 128) nPhase = 2;
        nTail = mTail + 1;
      end
      if (mPhase == 0 || anyCause) mProg = 0;
      else if (regWr) mProg = int'(regWrData);
      mQuiet  = anyCause ? 0 : mQuiet + 1;
      mSilent = rising ? 0 : mSilent + 1;
      mPhase = nPhase; mTail = nTail;
      pinHist.push_front(int'(lineClk)); void'(pinHist.pop_back());
      ceHist.push_front(int'(chipEnable)); void'(ceHist.pop_back());
      uvHist.push_front(int'(underVolt)); void'(uvHist.pop_back());
    end
  end

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge refClk) begin
    check(curReq, "intRstN", int'(intRstN), (mPhase != 0) ? 1 : 0);
    check("R6", "resIndN", int'(resIndN), (mPhase == 2) ? 1 : 0);
    check("R5 R7", "clkOutEn", int'(clkOutEn), (mPhase != 0) ? 3 : 0);
    check("R5 R7", "sdaOutEn", int'(sdaOutEn), (mPhase != 0) ? 1 : 0);
    check((curReq == "R9") ? "R9" : "R8", "progOutEn", int'(progOutEn), mProg);
  end

  task automatic cycles(int n);
    repeat (n) @(negedge refClk);
    #1;
  endtask

  task automatic writeEn(logic [NP-1:0] d);
    @(negedge refClk); #1;
    regWr = 1'b1; regWrData = d;
    @(negedge refClk); #1;
    regWr = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    cycles(3);
    // R10: outputs held during power-on reset
    check("R10", "intRstN in power-on", int'(intRstN), 0);
    check("R10", "resIndN in power-on", int'(resIndN), 0);
    rstN = 1'b1;
    // R8: a write while still held must be ignored
    cycles(2);
    writeEn(6'b111111);
    curReq = "R4";
    cycles(100);
    writeEn(6'b000101);          // R8: write during the tail
    cycles(600);
    check("R6", "indicator high after tail", int'(resIndN), 1);
    writeEn(6'b101010);          // R8
    cycles(20);
    check("R8", "programmed enables", int'(progOutEn), 6'b101010);

    curReq = "R3";
    chipEnable = 1'b0;
    cycles(10);
    check("R3", "held by chip enable", int'(intRstN), 0);
    chipEnable = 1'b1;
    cycles(700);
    writeEn(6'b010011);

    curReq = "R2";
    underVolt = 1'b1;
    cycles(1);
    underVolt = 1'b0;
    cycles(5);
    check("R2", "pulse enters reset", int'(intRstN), 0);
    cycles(700);

    curReq = "R1";
    lineRun = 1'b0;
    cycles(100);
    check("R1", "missing clock holds reset", int'(intRstN), 0);
    lineRun = 1'b1;
    cycles(700);

    curReq = "R9";
    underVolt = 1'b1;
    cycles(2);
    underVolt = 1'b0;
    cycles(60);
    writeEn(6'b110000);
    cycles(100);
    underVolt = 1'b1;            // R9: new cause inside the tail
    cycles(1);
    underVolt = 1'b0;
    cycles(30);
    check("R9", "enables cleared after restart", int'(progOutEn), 0);
    cycles(700);
    check("R9", "indicator high again", int'(resIndN), 1);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge refClk);
    mismatched++;
    compared++;
    $display("FAIL watchdog R4: actual timeout expected completion");
    finishRun();
  end
endmodule